// File: doc/BRIEF.md
# Serial Attenuator Programming Master

This block runs on the host side and programs an addressable step attenuator over a three-wire link. The link has serial data, a serial clock and a latch strobe. A request presents a 7-bit attenuation code and a 3-bit device address. The code is the wanted attenuation in dB multiplied by four, so 18.25 dB becomes 73.

When a request is accepted, the block packs a 16-bit frame and shifts it out least-significant bit first. The attenuation word goes out first and the address word follows it. The clock high and low phases, the data setup, the gap before the strobe and the strobe width are all given in nanoseconds. Each one is turned into whole system-clock cycles at elaboration, always rounding up.

The controller drops the serial clock after the last bit and waits out the setup time. It then raises the latch strobe for its minimum width and lowers it. A busy flag covers the whole transfer, and a one-cycle done pulse marks the end.

Top module: `atten_serial_master`

## Requirements
- R1: While reset is asserted and after it is released with no request, ser_clk, ser_le, ser_data, busy and done are all low.
- R2: A request is accepted only when req_valid is high while busy is low. A request raised while busy is high neither changes the frame in flight nor starts another transfer.
- R3: The first eight bits on ser_data are the attenuation word, sent bit 0 first. Bits 0..6 carry req_code[0..6] and bit 7 is sent as zero.
- R4: The next eight bits are the address word, sent bit 0 first. Bits 0..2 carry req_addr[0..2] and bits 3..7 are sent as zero.
- R5: Each high phase of ser_clk lasts exactly HI_CYC = ceil(SCK_HIGH_NS / SYS_PERIOD_NS) system cycles. HI_CYC is at least ceil(DATA_HOLD_NS / SYS_PERIOD_NS).
- R6: Each low phase before a rising edge lasts exactly LO_CYC system cycles. LO_CYC is the largest of three values: ceil(SCK_LOW_NS/T), ceil(DATA_SETUP_NS/T), and ceil(SCK_MIN_PERIOD_NS/T) - HI_CYC. With the defaults and a 20 ns clock this gives HI_CYC = 2 and LO_CYC = 3.
- R7: ser_data changes only at a falling edge of ser_clk (or at acceptance). It is stable through every low phase before a rising edge and through every high phase.
- R8: ser_le stays low while bits are shifted. It rises HI_CYC + SU_CYC cycles after the sixteenth rising edge of ser_clk, where SU_CYC = ceil(LE_SETUP_NS/T).
- R9: ser_le stays high for exactly LW_CYC = ceil(LE_WIDTH_NS/T) cycles and then returns low.
- R10: done is high for exactly one cycle: the first cycle in which ser_le is low again after the strobe.
- R11: busy rises in the cycle after acceptance, stays high through the done cycle, and is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_code | input | 7 | Attenuation code, dB times four |
| req_addr | input | 3 | Target device address |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| ser_clk | output | 1 | Serial clock to the attenuator |
| ser_data | output | 1 | Serial data to the attenuator |
| ser_le | output | 1 | Latch strobe to the attenuator |

## Verification
Every output is a flop, so each result is due a fixed number of cycles after the accepting edge:
- busy and frame bit 0 appear one cycle after acceptance.
- Each rising edge of ser_clk comes LO_CYC cycles after the preceding low phase began.
- The strobe rises HI_CYC + SU_CYC cycles after the last rising edge.
- done comes LW_CYC cycles after the strobe rises.

The bench samples on the falling system-clock edge and counts run lengths sample by sample. It compares each run against those counts, worked out from the nanosecond parameters in the bench itself. All 128 codes are swept with every address, and the captured bits are compared with the frame assembled by arithmetic.

// File: rtl/atten_ser_pkg.sv
package atten_ser_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_LOW   = 3'd1,
      PH_HIGH  = 3'd2,
      PH_SETUP = 3'd3,
      PH_LATCH = 3'd4,
      PH_DONE  = 3'd5
   } phase_e;

   // Nanoseconds to whole cycles, rounded up, never below one cycle.
   function automatic int ns_to_cyc(input int ns, input int period);
      int c;
      c = (ns + period - 1) / period;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/atten_frame_pack.sv
module atten_frame_pack #(
   parameter int CODE_W = 7,
   parameter int ADDR_W = 3,
   parameter int WORD_W = 8,
   localparam int FRAME_W = 2 * WORD_W
) (
   input  logic [CODE_W-1:0]  code,
   input  logic [ADDR_W-1:0]  addr,
   output logic [FRAME_W-1:0] frame
);

   if (CODE_W > WORD_W) begin : g_bad_code
      $error("atten_frame_pack: CODE_W exceeds WORD_W");
   end
   if (ADDR_W > WORD_W) begin : g_bad_addr
      $error("atten_frame_pack: ADDR_W exceeds WORD_W");
   end

   // Low word: attenuation code with zero fill on top.
   // High word: address with zero fill on top.
   for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      if (i < CODE_W) begin : g_code
         assign frame[i] = code[i];
      end else begin : g_code_pad
         assign frame[i] = 1'b0;
      end
      if (i < ADDR_W) begin : g_addr
         assign frame[WORD_W+i] = addr[i];
      end else begin : g_addr_pad
         assign frame[WORD_W+i] = 1'b0;
      end
   end

endmodule

// File: rtl/atten_phase_timer.sv
module atten_phase_timer #(
   parameter int TMR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TMR_W-1:0] load_val,
   output logic             expired
);

   if (TMR_W < 1) begin : g_bad_w
      $error("atten_phase_timer: TMR_W must be positive");
   end

   logic [TMR_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

   // R5
   tmr_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && expired) |=> expired)
      else $error("phase timer wrapped below zero");

endmodule

// File: rtl/atten_bit_shifter.sv
module atten_bit_shifter #(
   parameter int FRAME_W = 16,
   localparam int CNT_W = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame_in,
   input  logic               step,
   output logic               bit_out,
   output logic               last_bit
);

   if (FRAME_W < 2) begin : g_bad_frame
      $error("atten_bit_shifter: FRAME_W must be at least 2");
   end

   logic [FRAME_W-1:0] sh_q;
   logic [CNT_W-1:0]   left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         left_q <= '0;
      end else if (load) begin
         sh_q   <= frame_in;
         left_q <= CNT_W'(FRAME_W);
      end else if (step) begin
         sh_q   <= {1'b0, sh_q[FRAME_W-1:1]};
         left_q <= left_q - 1'b1;
      end
   end

   assign bit_out  = sh_q[0];
   assign last_bit = (left_q == CNT_W'(1));

   // R3
   shift_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (left_q > CNT_W'(1)))
      else $error("shift requested past the final bit");

endmodule

// File: rtl/atten_serial_master.sv
module atten_serial_master
   import atten_ser_pkg::*;
#(
   parameter int SYS_PERIOD_NS     = 20,
   parameter int SCK_HIGH_NS       = 30,
   parameter int SCK_LOW_NS        = 30,
   parameter int SCK_MIN_PERIOD_NS = 100,
   parameter int DATA_SETUP_NS     = 10,
   parameter int DATA_HOLD_NS      = 10,
   parameter int LE_SETUP_NS       = 10,
   parameter int LE_WIDTH_NS       = 30,
   parameter int CODE_W            = 7,
   parameter int ADDR_W            = 3,
   parameter int WORD_W            = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [CODE_W-1:0] req_code,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              busy,
   output logic              done,
   output logic              ser_clk,
   output logic              ser_data,
   output logic              ser_le
);

   localparam int FRAME_W = 2 * WORD_W;
   localparam int HI_CYC  = imax(ns_to_cyc(SCK_HIGH_NS, SYS_PERIOD_NS),
                                 ns_to_cyc(DATA_HOLD_NS, SYS_PERIOD_NS));
   localparam int LO_BASE = imax(ns_to_cyc(SCK_LOW_NS, SYS_PERIOD_NS),
                                 ns_to_cyc(DATA_SETUP_NS, SYS_PERIOD_NS));
   localparam int LO_CYC  = imax(LO_BASE,
                                 ns_to_cyc(SCK_MIN_PERIOD_NS, SYS_PERIOD_NS) - HI_CYC);
   localparam int SU_CYC  = ns_to_cyc(LE_SETUP_NS, SYS_PERIOD_NS);
   localparam int LW_CYC  = ns_to_cyc(LE_WIDTH_NS, SYS_PERIOD_NS);
   localparam int MAX_CYC = imax(imax(HI_CYC, LO_CYC), imax(SU_CYC, LW_CYC));
   localparam int TMR_W   = imax(1, $clog2(MAX_CYC + 1));

   localparam logic [TMR_W-1:0] HI_LD = TMR_W'(HI_CYC - 1);
   localparam logic [TMR_W-1:0] LO_LD = TMR_W'(LO_CYC - 1);
   localparam logic [TMR_W-1:0] SU_LD = TMR_W'(SU_CYC - 1);
   localparam logic [TMR_W-1:0] LW_LD = TMR_W'(LW_CYC - 1);

   if (SYS_PERIOD_NS < 1) begin : g_bad_period
      $error("atten_serial_master: SYS_PERIOD_NS must be positive");
   end
   if (CODE_W < 1 || ADDR_W < 1 || WORD_W < 1) begin : g_bad_width
      $error("atten_serial_master: field widths must be positive");
   end
   if (HI_CYC + LO_CYC < ns_to_cyc(SCK_MIN_PERIOD_NS, SYS_PERIOD_NS)) begin : g_bad_rate
      $error("atten_serial_master: serial clock period below minimum");
   end

   phase_e           state_q, state_d;
   logic             sck_q, sck_d;
   logic             le_q, le_d;
   logic             done_q, done_d;
   logic             tmr_load;
   logic [TMR_W-1:0] tmr_val;
   logic             tmr_exp;
   logic             shf_load, shf_step, shf_last, shf_bit;
   logic [FRAME_W-1:0] frame;

   atten_frame_pack #(
      .CODE_W (CODE_W),
      .ADDR_W (ADDR_W),
      .WORD_W (WORD_W)
   ) pack_i (
      .code  (req_code),
      .addr  (req_addr),
      .frame (frame)
   );

   atten_phase_timer #(
      .TMR_W (TMR_W)
   ) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   atten_bit_shifter #(
      .FRAME_W (FRAME_W)
   ) shifter_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (shf_load),
      .frame_in (frame),
      .step     (shf_step),
      .bit_out  (shf_bit),
      .last_bit (shf_last)
   );

   always_comb begin
      state_d  = state_q;
      sck_d    = sck_q;
      le_d     = le_q;
      done_d   = 1'b0;
      tmr_load = 1'b0;
      tmr_val  = LO_LD;
      shf_load = 1'b0;
      shf_step = 1'b0;
      unique case (state_q)
         PH_IDLE: begin
            if (req_valid) begin
               state_d  = PH_LOW;
               tmr_load = 1'b1;
               tmr_val  = LO_LD;
               shf_load = 1'b1;
            end
         end
         PH_LOW: begin
            if (tmr_exp) begin
               state_d  = PH_HIGH;
               sck_d    = 1'b1;
               tmr_load = 1'b1;
               tmr_val  = HI_LD;
            end
         end
         PH_HIGH: begin
            if (tmr_exp) begin
               sck_d    = 1'b0;
               tmr_load = 1'b1;
               if (shf_last) begin
                  state_d = PH_SETUP;
                  tmr_val = SU_LD;
               end else begin
                  state_d  = PH_LOW;
                  tmr_val  = LO_LD;
                  shf_step = 1'b1;
               end
            end
         end
         PH_SETUP: begin
            if (tmr_exp) begin
               state_d  = PH_LATCH;
               le_d     = 1'b1;
               tmr_load = 1'b1;
               tmr_val  = LW_LD;
            end
         end
         PH_LATCH: begin
            if (tmr_exp) begin
               state_d = PH_DONE;
               le_d    = 1'b0;
               done_d  = 1'b1;
            end
         end
         PH_DONE: begin
            state_d = PH_IDLE;
         end
         default: begin
            state_d = PH_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PH_IDLE;
         sck_q   <= 1'b0;
         le_q    <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         sck_q   <= sck_d;
         le_q    <= le_d;
         done_q  <= done_d;
      end
   end

   assign busy     = (state_q != PH_IDLE);
   assign done     = done_q;
   assign ser_clk  = sck_q;
   assign ser_le   = le_q;
   assign ser_data = shf_bit;

   // R8
   le_quiet_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_LOW || state_q == PH_HIGH) |-> !ser_le)
      else $error("latch strobe high during shifting");

   // R7
   data_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && $past(ser_clk)) |-> $stable(ser_data))
      else $error("serial data moved while clock high");

   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done longer than one cycle");

   // R10
   done_after_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(ser_le) && !ser_le))
      else $error("done not aligned to strobe fall");

   // R11
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy)
      else $error("busy dropped before done");

   // R8
   le_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_le |-> !ser_clk)
      else $error("serial clock high with strobe");

endmodule

// File: tb/atten_serial_master_tb_top.sv
module atten_serial_master_tb_top;

   localparam int PER   = 20;
   localparam int T_HI  = 30;
   localparam int T_LO  = 30;
   localparam int T_MP  = 100;
   localparam int T_DS  = 10;
   localparam int T_DH  = 10;
   localparam int T_LS  = 10;
   localparam int T_LW  = 30;

   function automatic int cdiv(input int a);
      int c;
      c = (a + PER - 1) / PER;
      return (c < 1) ? 1 : c;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int H = mx(cdiv(T_HI), cdiv(T_DH));
   localparam int L = mx(mx(cdiv(T_LO), cdiv(T_DS)), cdiv(T_MP) - H);
   localparam int S = cdiv(T_LS);
   localparam int W = cdiv(T_LW);

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [6:0] req_code = '0;
   logic [2:0] req_addr = '0;
   logic       busy, done, ser_clk, ser_data, ser_le;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  finished = 1'b0;

   always #10 clk = ~clk;

   atten_serial_master #(
      .SYS_PERIOD_NS     (PER),
      .SCK_HIGH_NS       (T_HI),
      .SCK_LOW_NS        (T_LO),
      .SCK_MIN_PERIOD_NS (T_MP),
      .DATA_SETUP_NS     (T_DS),
      .DATA_HOLD_NS      (T_DH),
      .LE_SETUP_NS       (T_LS),
      .LE_WIDTH_NS       (T_LW),
      .CODE_W            (7),
      .ADDR_W            (3),
      .WORD_W            (8)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_code  (req_code),
      .req_addr  (req_addr),
      .busy      (busy),
      .done      (done),
      .ser_clk   (ser_clk),
      .ser_data  (ser_data),
      .ser_le    (ser_le)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic run_txn(input int code, input int addr, input bit inject);
      logic [15:0] exp_f;
      logic [15:0] got;
      int  nb, lo_run, hi_run, since_rise, le_run;
      bit  p_sck, p_le, p_data, fell, fin;
      exp_f = {5'b0, addr[2:0], 1'b0, code[6:0]};
      got = '0;
      @(negedge clk);
      req_valid = 1'b1;
      req_code  = code[6:0];
      req_addr  = addr[2:0];
      @(negedge clk);
      req_valid = 1'b0;
      check(busy === 1'b1, "R11", "busy after accept", int'(busy), 1);
      check(ser_data === exp_f[0], "R3", "first data bit", int'(ser_data), int'(exp_f[0]));
      p_sck = ser_clk; p_le = ser_le; p_data = ser_data;
      lo_run = 1; hi_run = 0; since_rise = 0; le_run = 0; nb = 0;
      fell = 1'b0; fin = 1'b0;
      for (int idx = 1; idx < 3000 && !fin; idx++) begin
         @(negedge clk);
         if (inject && idx == 10) begin
            req_valid = 1'b1;
            req_code  = ~code[6:0];
            req_addr  = ~addr[2:0];
         end
         if (inject && idx == 12) req_valid = 1'b0;
         if (fell) begin
            check(done === 1'b0, "R10", "done after pulse", int'(done), 0);
            check(busy === 1'b0, "R11", "busy after done", int'(busy), 0);
            fin = 1'b1;
         end else begin
            since_rise++;
            if (ser_clk && !p_sck) begin
               check(lo_run == L, "R6", "low phase length", lo_run, L);
               check(ser_data === p_data, "R7", "data setup stable", int'(ser_data), int'(p_data));
               if (nb < 16) got[nb] = ser_data;
               nb++;
               hi_run = 1;
               since_rise = 0;
            end else if (!ser_clk && p_sck) begin
               check(hi_run == H, "R5", "high phase length", hi_run, H);
               lo_run = 1;
            end else if (ser_clk) begin
               hi_run++;
               if (ser_data !== p_data)
                  check(1'b0, "R7", "data moved while high", int'(ser_data), int'(p_data));
            end else begin
               lo_run++;
            end
            if (ser_le && !p_le) begin
               check(nb == 16, "R8", "bits before strobe", nb, 16);
               check(since_rise == H + S, "R8", "strobe gap", since_rise, H + S);
               le_run = 1;
            end else if (ser_le) begin
               le_run++;
            end else if (p_le) begin
               check(le_run == W, "R9", "strobe width", le_run, W);
               check(done === 1'b1, "R10", "done at strobe fall", int'(done), 1);
               check(busy === 1'b1, "R11", "busy during done", int'(busy), 1);
               fell = 1'b1;
            end
            if (done && !fell)
               check(1'b0, "R10", "early done", int'(done), 0);
            p_sck = ser_clk; p_le = ser_le; p_data = ser_data;
         end
      end
      check(fin, "R10", "transfer finished", int'(fin), 1);
      check(got[7:0] == exp_f[7:0], "R3", "attenuation word", int'(got[7:0]), int'(exp_f[7:0]));
      check(got[15:8] == exp_f[15:8], "R4", "address word", int'(got[15:8]), int'(exp_f[15:8]));
      if (inject) begin
         for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(busy === 1'b0 && ser_clk === 1'b0, "R2", "no queued transfer",
                  int'(busy), 0);
         end
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog run hung actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1 outputs during reset
      check({ser_clk, ser_le, ser_data, busy, done} === 5'b0, "R1", "reset outputs",
            int'({ser_clk, ser_le, ser_data, busy, done}), 0);
      rst_n = 1'b1;
      repeat (4) begin
         @(negedge clk);
         check({ser_clk, ser_le, ser_data, busy, done} === 5'b0, "R1", "idle outputs",
               int'({ser_clk, ser_le, ser_data, busy, done}), 0);
      end
      // R3 R4 worked example: 18.25 dB at address 3
      run_txn(73, 3, 1'b0);
      // R2 requests raised while busy are dropped
      run_txn(5, 6, 1'b1);
      run_txn(127, 7, 1'b1);
      // R3 R4 sweep of every code, every address reached
      for (int c = 0; c < 128; c++) begin
         run_txn(c, (c & 7) ^ ((c >> 3) & 7), 1'b0);
      end
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule